// File: doc/BRIEF.md
# ADC Engine Window-Compare Register Block

This block is the register file of a single analog-to-digital converter engine, reached over a simple 32-bit memory-mapped port with a 256-byte window. It keeps the sample words (two 10-bit channels packed per word), a lower/upper limit word per channel, a hysteresis word per channel, and the control, clock, detect, interrupt and trim words. No converter sits behind it. Each sample word advances with a fixed deterministic step every time it is read, so the block can be exercised on its own.

Each read of a sample word also tests the two channels of that word against their limits. If either channel falls outside its window, the block latches a status bit for that channel pair and raises a level interrupt. The interrupt stays high until software writes the status bits back to zero. A parameter selects a 16-channel or an 8-channel engine. In the 8-channel build, the registers of the upper eight channels read as zero and drop writes.

Top module: `adcwin_regs`

## Requirements
- R1: After reset, control, interrupt control, interrupt source, trim, all sample, limit and hysteresis words read 0; detect control and clock control read 0x0000000F; irq_out is low.
- R2: A read issued with bus_rd returns bus_rdata with bus_rvalid high on the following cycle. A cycle with both bus_wr and bus_rd performs only the write.
- R3: Sample pair i sits at byte offset 0x10+4i, even channel in bits 9:0 and odd channel in bits 25:16. The limit word of channel k sits at 0x30+4k, lower limit in bits 9:0 and upper limit in bits 25:16. Writes to both keep only those two fields.
- R4: The hysteresis word of channel k at 0x70+4k keeps bit 31 and bits 25:16 and 9:0. Interrupt source at 0xC0 keeps bits 15:0. Trim at 0xC4 keeps bits 3:0.
- R5: A write to control (0x00) stores bit 8 equal to the written bit 0, forces bit 5 to 0, and stores every other bit as written.
- R6: A sample-pair read returns the stored value. The stored pair then advances: the even field adds 5 and the odd field adds 7, each modulo 1024.
- R7: On a sample-pair read, the advanced even value is compared with limit word 2i and the advanced odd value with limit word 2i+1. A value strictly below its lower or strictly above its upper limit sets bit i of interrupt control (0x04). Values equal to a limit do not set it.
- R8: irq_out is high exactly while any of interrupt control bits 7:0 is set, one cycle after the register changes, and it goes low after software writes those bits to 0.
- R9: A read with bus_half high at a sample-pair address with byte-address bit 1 set returns bits 31:16 of the stored word in bits 15:0, with the upper half zero.
- R10: With NUM_CH=8, sample pairs 4–7 (0x20–0x2C), limits 8–15 (0x50–0x6C) and hysteresis 8–15 (0x90–0xAC) read as 0 and ignore writes, and reading them sets no status bit.
- R11: Offsets outside the map (for example 0xB0, 0xC8) and any address with byte bit 0 set read as 0 and ignore writes.
- R12: Interrupt control (0x04), detect control (0x08) and clock control (0x0C) store all 32 written bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_half | input | 1 | Read is 16 bits wide |
| bus_addr | input | AW (8) | Byte address inside the engine window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq_out | output | 1 | Level interrupt from status bits 7:0 |

## Verification
The hardest case to reach is a sample that lands exactly on a limit and then moves one step beyond it. The samples are never written directly by a converter; they only move by the fixed step on each read. The stimulus therefore writes a pair chosen so that successive reads step the even channel to 10, 15, 20 and then 25 against a 10..20 window, and it checks that the status bit appears only on the fourth read. A separate pair is placed just below 1024 so that both fields wrap during stepping. A second instance built with eight channels is driven with the same traffic, to show that the upper registers stay silent there.

// File: rtl/adcwin_pkg.sv
package adcwin_pkg;
  localparam int DW      = 32;
  localparam int SMP_W   = 10;
  localparam int HI_LSB  = 16;
  localparam int PAD_W   = HI_LSB - SMP_W;
  localparam int TOP_PAD = DW - HI_LSB - SMP_W;
  localparam int MAX_CH  = 16;
  localparam int IRQ_W   = MAX_CH / 2;
  localparam int ISRC_W  = 16;
  localparam int TRIM_W  = 4;

  localparam logic [SMP_W-1:0] STEP_LO = SMP_W'(5);
  localparam logic [SMP_W-1:0] STEP_HI = SMP_W'(7);

  localparam int CTL_EN_BIT    = 0;
  localparam int CTL_AUTOC_BIT = 5;
  localparam int CTL_INIT_BIT  = 8;

  localparam logic [DW-1:0] DET_RST = 32'h0000_000F;
  localparam logic [DW-1:0] CLK_RST = 32'h0000_000F;

  // word offsets (byte offset / 4)
  localparam int W_CTL  = 0;
  localparam int W_ICTL = 1;
  localparam int W_DET  = 2;
  localparam int W_CLK  = 3;
  localparam int W_DATA = 4;
  localparam int W_BND  = 12;
  localparam int W_HYST = 28;
  localparam int W_ISRC = 48;
  localparam int W_TRIM = 49;

  typedef enum logic [3:0] {
    K_NONE, K_CTL, K_ICTL, K_DET, K_CLK, K_DATA, K_BND, K_HYST, K_ISRC, K_TRIM
  } reg_kind_e;

  typedef struct packed {
    logic [SMP_W-1:0] hi;
    logic [SMP_W-1:0] lo;
  } pair_t;

  typedef struct packed {
    logic             en;
    logic [SMP_W-1:0] hi;
    logic [SMP_W-1:0] lo;
  } hyst_t;

  function automatic logic [DW-1:0] pack_pair(input pair_t p);
    return {{TOP_PAD{1'b0}}, p.hi, {PAD_W{1'b0}}, p.lo};
  endfunction

  function automatic logic [DW-1:0] pack_hyst(input hyst_t h);
    return {h.en, {(TOP_PAD-1){1'b0}}, h.hi, {PAD_W{1'b0}}, h.lo};
  endfunction
endpackage

// File: rtl/adcwin_decode.sv
module adcwin_decode
  import adcwin_pkg::*;
#(
  parameter int WA_W   = 6,
  parameter int NUM_CH = 16
) (
  input  logic [WA_W-1:0]           word_addr,
  input  logic                      misaligned,
  output reg_kind_e                 kind,
  output logic [$clog2(NUM_CH)-1:0] idx
);
  localparam int CH_IW    = $clog2(NUM_CH);
  localparam int NUM_PAIR = NUM_CH / 2;

  int unsigned w;

  always_comb begin
    w    = 32'(word_addr);
    kind = K_NONE;
    idx  = '0;
    if (misaligned) begin
      kind = K_NONE;
    end else if (w == W_CTL) begin
      kind = K_CTL;
    end else if (w == W_ICTL) begin
      kind = K_ICTL;
    end else if (w == W_DET) begin
      kind = K_DET;
    end else if (w == W_CLK) begin
      kind = K_CLK;
    end else if (w >= W_DATA && w < W_DATA + NUM_PAIR) begin
      kind = K_DATA;
      idx  = CH_IW'(w - W_DATA);
    end else if (w >= W_BND && w < W_BND + NUM_CH) begin
      kind = K_BND;
      idx  = CH_IW'(w - W_BND);
    end else if (w >= W_HYST && w < W_HYST + NUM_CH) begin
      kind = K_HYST;
      idx  = CH_IW'(w - W_HYST);
    end else if (w == W_ISRC) begin
      kind = K_ISRC;
    end else if (w == W_TRIM) begin
      kind = K_TRIM;
    end
  end
endmodule

// File: rtl/adcwin_chan_regs.sv
module adcwin_chan_regs #(
  parameter int  DEPTH   = 16,
  parameter int  NRD     = 1,
  parameter type ENTRY_T = logic [7:0]
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                wr_en,
  input  logic [$clog2(DEPTH)-1:0]            wr_idx,
  input  ENTRY_T                              wr_data,
  input  logic [NRD-1:0][$clog2(DEPTH)-1:0]   rd_idx,
  output ENTRY_T [NRD-1:0]                    rd_data
);
  ENTRY_T mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd_data[g] = mem[rd_idx[g]];
  end
endmodule

// File: rtl/adcwin_sample_bank.sv
module adcwin_sample_bank
  import adcwin_pkg::*;
#(
  parameter int NUM_PAIR = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        step_en,
  input  logic [$clog2(NUM_PAIR)-1:0] idx,
  input  pair_t                       wr_pair,
  output pair_t                       cur,
  output pair_t                       stepped
);
  pair_t mem [NUM_PAIR];

  assign cur          = mem[idx];
  assign stepped.lo   = cur.lo + STEP_LO;
  assign stepped.hi   = cur.hi + STEP_HI;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_PAIR; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[idx] <= wr_pair;
    end else if (step_en) begin
      mem[idx] <= stepped;
    end
  end

  // R6: the pair read advances by the fixed step, wrapping in the field width
  assert_step_R6: assert property (@(posedge clk) disable iff (rst)
    (step_en && !wr_en) |=>
      (mem[$past(idx)].lo == SMP_W'($past(cur.lo) + STEP_LO)) &&
      (mem[$past(idx)].hi == SMP_W'($past(cur.hi) + STEP_HI)));
endmodule

// File: rtl/adcwin_limit_check.sv
module adcwin_limit_check
  import adcwin_pkg::*;
(
  input  pair_t smp,
  input  pair_t lim_even,
  input  pair_t lim_odd,
  output logic  outside
);
  logic even_out;
  logic odd_out;

  // limit word: lo field = lower limit, hi field = upper limit
  assign even_out = (smp.lo < lim_even.lo) || (smp.lo > lim_even.hi);
  assign odd_out  = (smp.hi < lim_odd.lo)  || (smp.hi > lim_odd.hi);
  assign outside  = even_out || odd_out;
endmodule

// File: rtl/adcwin_regs.sv
module adcwin_regs
  import adcwin_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int AW     = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic          bus_half,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          irq_out
);
  localparam int NUM_PAIR = NUM_CH / 2;
  localparam int CH_IW    = $clog2(NUM_CH);
  localparam int PR_IW    = CH_IW - 1;

  reg_kind_e          kind;
  logic [CH_IW-1:0]   idx;
  logic [PR_IW-1:0]   pair_idx;
  logic               rd_fire;
  logic               outside;

  pair_t              wr_pair;
  hyst_t              wr_hyst;
  pair_t              smp_cur;
  pair_t              smp_next;
  pair_t [1:0]        bnd_rd;
  hyst_t [0:0]        hyst_rd;
  logic [1:0][CH_IW-1:0] bnd_idx;
  logic [0:0][CH_IW-1:0] hyst_idx;

  logic [DW-1:0]      ctl_q, ictl_q, det_q, clk_q;
  logic [ISRC_W-1:0]  isrc_q;
  logic [TRIM_W-1:0]  trim_q;
  logic [DW-1:0]      ctl_n, ictl_n, rd_mux;

  adcwin_decode #(.WA_W(AW - 2), .NUM_CH(NUM_CH)) u_dec (
    .word_addr (bus_addr[AW-1:2]),
    .misaligned(bus_addr[0]),
    .kind      (kind),
    .idx       (idx)
  );

  assign rd_fire  = bus_rd && !bus_wr;
  assign pair_idx = idx[PR_IW-1:0];

  assign wr_pair.hi = bus_wdata[HI_LSB +: SMP_W];
  assign wr_pair.lo = bus_wdata[0 +: SMP_W];
  assign wr_hyst.en = bus_wdata[DW-1];
  assign wr_hyst.hi = bus_wdata[HI_LSB +: SMP_W];
  assign wr_hyst.lo = bus_wdata[0 +: SMP_W];

  adcwin_sample_bank #(.NUM_PAIR(NUM_PAIR)) u_bank (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr && kind == K_DATA),
    .step_en(rd_fire && kind == K_DATA),
    .idx    (pair_idx),
    .wr_pair(wr_pair),
    .cur    (smp_cur),
    .stepped(smp_next)
  );

  // port 0 serves host reads of limits, or the even limit during a pair read
  assign bnd_idx[0]  = (kind == K_DATA) ? {pair_idx, 1'b0} : idx;
  assign bnd_idx[1]  = {pair_idx, 1'b1};
  assign hyst_idx[0] = idx;

  adcwin_chan_regs #(.DEPTH(NUM_CH), .NRD(2), .ENTRY_T(pair_t)) u_bnd (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr && kind == K_BND),
    .wr_idx (idx),
    .wr_data(wr_pair),
    .rd_idx (bnd_idx),
    .rd_data(bnd_rd)
  );

  adcwin_chan_regs #(.DEPTH(NUM_CH), .NRD(1), .ENTRY_T(hyst_t)) u_hyst (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (bus_wr && kind == K_HYST),
    .wr_idx (idx),
    .wr_data(wr_hyst),
    .rd_idx (hyst_idx),
    .rd_data(hyst_rd)
  );

  adcwin_limit_check u_lim (
    .smp     (smp_next),
    .lim_even(bnd_rd[0]),
    .lim_odd (bnd_rd[1]),
    .outside (outside)
  );

  always_comb begin
    ctl_n                = bus_wdata;
    ctl_n[CTL_INIT_BIT]  = bus_wdata[CTL_EN_BIT];
    ctl_n[CTL_AUTOC_BIT] = 1'b0;
  end

  always_comb begin
    ictl_n = ictl_q;
    if (bus_wr && kind == K_ICTL) ictl_n = bus_wdata;
    if (rd_fire && kind == K_DATA && outside) ictl_n[pair_idx] = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    unique case (kind)
      K_CTL:  rd_mux = ctl_q;
      K_ICTL: rd_mux = ictl_q;
      K_DET:  rd_mux = det_q;
      K_CLK:  rd_mux = clk_q;
      K_DATA: begin
        rd_mux = pack_pair(smp_cur);
        if (bus_half && bus_addr[1]) rd_mux = {{HI_LSB{1'b0}}, rd_mux[DW-1:HI_LSB]};
      end
      K_BND:  rd_mux = pack_pair(bnd_rd[0]);
      K_HYST: rd_mux = pack_hyst(hyst_rd[0]);
      K_ISRC: rd_mux = {{(DW-ISRC_W){1'b0}}, isrc_q};
      K_TRIM: rd_mux = {{(DW-TRIM_W){1'b0}}, trim_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q      <= '0;
      ictl_q     <= '0;
      det_q      <= DET_RST;
      clk_q      <= CLK_RST;
      isrc_q     <= '0;
      trim_q     <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      irq_out    <= 1'b0;
    end else begin
      if (bus_wr && kind == K_CTL)  ctl_q  <= ctl_n;
      if (bus_wr && kind == K_DET)  det_q  <= bus_wdata;
      if (bus_wr && kind == K_CLK)  clk_q  <= bus_wdata;
      if (bus_wr && kind == K_ISRC) isrc_q <= bus_wdata[ISRC_W-1:0];
      if (bus_wr && kind == K_TRIM) trim_q <= bus_wdata[TRIM_W-1:0];
      ictl_q     <= ictl_n;
      irq_out    <= |ictl_n[IRQ_W-1:0];
      bus_rvalid <= rd_fire;
      bus_rdata  <= rd_fire ? rd_mux : '0;
    end
  end

  // R2: read data valid exactly one cycle after an accepted read
  assert_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    rd_fire |=> bus_rvalid);
  assert_no_rvalid_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_fire |=> !bus_rvalid);

  // R5: init bit follows enable, auto-compensate cleared
  assert_ctl_init_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && kind == K_CTL) |=>
      (ctl_q[CTL_INIT_BIT] == $past(bus_wdata[CTL_EN_BIT])) && !ctl_q[CTL_AUTOC_BIT]);

  // R7: an out-of-window pair read latches the pair's status bit
  assert_pair_bit_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && kind == K_DATA && outside) |=> ictl_q[$past(pair_idx)] && irq_out);

  // R8: interrupt level tracks the low status bits
  assert_irq_level_R8: assert property (@(posedge clk) disable iff (rst)
    irq_out == (|ictl_q[IRQ_W-1:0]));

  // R11: unmapped reads return zero, unmapped writes change nothing
  assert_unmapped_rd_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_fire && kind == K_NONE) |=> bus_rdata == '0);
  assert_unmapped_wr_R11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && kind == K_NONE) |=> $stable(ctl_q) && $stable(ictl_q) && $stable(det_q));
endmodule

// File: tb/tb_adcwin_regs.sv
`timescale 1ns/1ps
module tb_adcwin_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, bus_half = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rdata, rdata8;
  logic        rvalid, rvalid8, irq, irq8;

  always #2 clk = ~clk;

  adcwin_regs #(.NUM_CH(16)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_half(bus_half),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata),
    .bus_rvalid(rvalid), .irq_out(irq));

  adcwin_regs #(.NUM_CH(8)) dut8 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_half(bus_half),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata8),
    .bus_rvalid(rvalid8), .irq_out(irq8));

  typedef struct {
    logic [31:0] e16;
    logic [31:0] e8;
    string       req;
  } exp_t;

  exp_t sb[$];
  exp_t got;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 0;

  logic [31:0] m_data [8];
  logic [31:0] m_bnd  [16];
  logic [31:0] m_hyst [16];
  logic [31:0] m_ctl = 0, m_ictl = 0, m_ictl8 = 0;
  logic [31:0] m_det = 32'hF, m_clk = 32'hF, m_isrc = 0, m_trim = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per returned read
  always @(negedge clk) begin
    if (!rst && (rvalid || rvalid8)) begin
      total++;
      if (sb.size() == 0) begin
        bad++;
        $display("FAIL R2: unexpected rvalid actual=%h expected=none", rdata);
      end else begin
        got = sb.pop_front();
        if (!rvalid || !rvalid8 || rdata !== got.e16 || rdata8 !== got.e8) begin
          bad++;
          $display("FAIL %s: actual=%h/%h expected=%h/%h", got.req, rdata, rdata8, got.e16, got.e8);
        end
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    int w;
    w = int'(a[7:2]);
    if (!a[0]) begin
      if (w == 0) m_ctl = (d & ~32'h120) | {23'b0, d[0], 8'b0};
      else if (w == 1) begin m_ictl = d; m_ictl8 = d; end
      else if (w == 2) m_det = d;
      else if (w == 3) m_clk = d;
      else if (w >= 4 && w <= 11) m_data[w-4] = d & 32'h03FF03FF;
      else if (w >= 12 && w <= 27) m_bnd[w-12] = d & 32'h03FF03FF;
      else if (w >= 28 && w <= 43) m_hyst[w-28] = d & 32'h83FF03FF;
      else if (w == 48) m_isrc = d & 32'hFFFF;
      else if (w == 49) m_trim = d & 32'hF;
    end
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit half, input string req);
    exp_t e;
    int w, p;
    logic [31:0] v;
    logic [9:0] nlo, nhi;
    bit up8;
    w = int'(a[7:2]); v = 0; up8 = 0;
    if (!a[0]) begin
      if (w == 0) v = m_ctl;
      else if (w == 1) v = m_ictl;
      else if (w == 2) v = m_det;
      else if (w == 3) v = m_clk;
      else if (w >= 4 && w <= 11) begin
        p = w - 4;
        v = m_data[p];
        up8 = (p >= 4);
        nlo = v[9:0] + 10'd5;
        nhi = v[25:16] + 10'd7;
        m_data[p] = {6'b0, nhi, 6'b0, nlo};
        if (nlo < m_bnd[2*p][9:0] || nlo > m_bnd[2*p][25:16] ||
            nhi < m_bnd[2*p+1][9:0] || nhi > m_bnd[2*p+1][25:16]) begin
          m_ictl[p] = 1'b1;
          if (!up8) m_ictl8[p] = 1'b1;
        end
        if (half && a[1]) v = {16'h0, v[31:16]};
      end
      else if (w >= 12 && w <= 27) begin v = m_bnd[w-12]; up8 = (w - 12) >= 8; end
      else if (w >= 28 && w <= 43) begin v = m_hyst[w-28]; up8 = (w - 28) >= 8; end
      else if (w == 48) v = m_isrc;
      else if (w == 49) v = m_trim;
    end
    e.e16 = v;
    e.e8  = up8 ? 32'h0 : ((w == 1 && !a[0]) ? m_ictl8 : v);
    e.req = req;
    sb.push_back(e);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a; bus_half = half;
    @(negedge clk);
    bus_rd = 1'b0; bus_half = 1'b0;
    chk("R8 irq level", {31'b0, irq}, {31'b0, |m_ictl[7:0]});
  endtask

  initial begin
    for (int i = 0; i < 8; i++) m_data[i] = 0;
    for (int i = 0; i < 16; i++) begin m_bnd[i] = 0; m_hyst[i] = 0; end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R1: reset contents
    rd(8'h00, 0, "R1"); rd(8'h04, 0, "R1"); rd(8'h08, 0, "R1"); rd(8'h0C, 0, "R1");
    rd(8'hC0, 0, "R1"); rd(8'hC4, 0, "R1"); rd(8'h30, 0, "R1"); rd(8'h70, 0, "R1");

    // R12: full-width control words
    wr(8'h08, 32'hDEADBEEF); rd(8'h08, 0, "R12");
    wr(8'h0C, 32'h12345678); rd(8'h0C, 0, "R12");
    wr(8'h04, 32'h00000100); rd(8'h04, 0, "R12");

    // R5: init follows enable, auto-compensate cleared
    wr(8'h00, 32'hFFFF0E2F); rd(8'h00, 0, "R5");
    wr(8'h00, 32'h00000132); rd(8'h00, 0, "R5");

    // R4 / R3: write masks
    wr(8'hC0, 32'hFFFFFFFF); rd(8'hC0, 0, "R4");
    wr(8'hC4, 32'hFFFFFFFF); rd(8'hC4, 0, "R4");
    wr(8'h70, 32'hFFFFFFFF); rd(8'h70, 0, "R4");
    wr(8'hAC, 32'hFFFFFFFF); rd(8'hAC, 0, "R10");
    wr(8'h34, 32'hFFFFFFFF); rd(8'h34, 0, "R3");
    wr(8'h14, 32'hFFFFFFFF); rd(8'h14, 0, "R3");  // zero limits: pair 1 flags
    chk("R8 irq held", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);

    // open every window
    for (int ch = 0; ch < 16; ch++) wr(8'(8'h30 + 4*ch), 32'h03FF0000);

    // R6: returned value then step with wrap; R9: halfword
    wr(8'h10, 32'h03FF03FE);
    rd(8'h10, 0, "R6"); rd(8'h10, 0, "R6 wrap");
    rd(8'h12, 1, "R9"); rd(8'h10, 0, "R6");

    // R7: equality with a limit stays inside, one step beyond flags
    wr(8'h38, 32'h0014000A);
    wr(8'h14, 32'h00640005);
    rd(8'h14, 0, "R7 at lower"); rd(8'h14, 0, "R7 inside");
    rd(8'h14, 0, "R7 at upper"); rd(8'h14, 0, "R7 above");
    chk("R7 irq raised", {31'b0, irq}, 32'h1);
    wr(8'h04, 32'h0);

    // R7: odd channel below its lower limit flags the pair index
    wr(8'h4C, 32'h03FF01F4);
    wr(8'h1C, 32'h0);
    rd(8'h1C, 0, "R7 odd low"); rd(8'h04, 0, "R7 pair bit");
    wr(8'h04, 32'h0);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);

    // R10: upper channel registers in the 8-channel build
    wr(8'h20, 32'h01230045); rd(8'h20, 0, "R10");
    wr(8'h50, 32'h02000100); rd(8'h50, 0, "R10");
    wr(8'h90, 32'h80010002); rd(8'h90, 0, "R10");
    rd(8'h04, 0, "R10");

    // R11: unmapped and misaligned
    wr(8'hB0, 32'hFFFFFFFF); rd(8'hB0, 0, "R11");
    rd(8'hC8, 0, "R11");
    wr(8'h05, 32'hFFFFFFFF); rd(8'h04, 0, "R11");
    rd(8'h01, 0, "R11");

    repeat (3) @(negedge clk);
    chk("R2 all reads returned", sb.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule